// File: doc/BRIEF.md
# Freezable Event Counter Bank

This block is a bank of hardware counters for watching the activity of a memory controller. Slot 0 holds a 64-bit counter that advances on every clock while the bank runs. Slots 1 to 10 each hold a 32-bit counter. Each of these counters follows one event line, chosen by a 7-bit code in its local control register. Event lines arrive as per-cycle pulses. A 64-bit vector is shared by all selectable slots, and each slot also has a small private vector of its own. Software reads and writes all state through a 32-bit register port with single-cycle writes and combinational reads.

Counting is governed at two levels. A global freeze bit stops every slot and overrides the per-slot freeze bits. A controller tracks the global freeze state with three states. ST_HALT is the frozen state entered at reset and on a freeze write. ST_RUN is the counting state. ST_TRIPPED is a frozen state entered by hardware. The transitions are as follows. RUN goes to TRIPPED on an enabled overflow, and this takes priority over a same-cycle write. RUN goes to HALT on a global write with the freeze bit set. HALT goes to RUN on a global write with the freeze bit clear. TRIPPED goes to HALT on a freeze write and to RUN on an unfreeze write.

An overflow is a counter's top bit going from 0 to 1 through counting. When the slot's condition enable and both global enables are set, the overflow freezes the whole bank and raises the level-sensitive interrupt. Software reads the counts, clears the top bit of the counter that overflowed, and writes the freeze bit low to resume.

Top module: `evmon_bank`

## Requirements
- R1: After reset the global register reads 0x8000_0000 (frozen, both enables clear), every slot's control and count read 0, and `irq` is low.
- R2: A selectable slot that is running and not locally frozen adds exactly 1 on each clock edge where its chosen event is high. Codes 0 to 63 choose `shared_evt[code]`. Codes 64 to 64+OWN_N-1 choose bit code-64 of that slot's private vector, and slot k's private vector is `own_evt[(k-1)*OWN_N +: OWN_N]`. Any higher code counts nothing.
- R3: Slot 0 is a 64-bit counter that adds 1 on every edge while the bank runs and slot 0 is not locally frozen, ignoring its event code. Its low half is at 0x58 and its high half at 0x5C, and a carry out of the low half increments the high half.
- R4: While the global freeze bit (bit 31 at 0x40) reads 1, no counter changes except by a software write, whatever the local freeze bits say.
- R5: A slot whose local freeze bit (bit 31 of its control A) is set does not count, while other slots on the same event keep counting.
- R6: When a counting increment moves a slot's top bit from 0 to 1 with its condition enable (control A bit 26), global interrupt enable (bit 30) and global freeze-on-condition (bit 29) all set, the global freeze bit becomes 1 at that same edge and no counter advances afterwards.
- R7: `irq` is high exactly while both global enables are set and at least one slot has its condition enable and its count's top bit set. It drops once that top bit is cleared, and it stays high across an unfreeze if the top bit is left set.
- R8: After a trip, writing the global register with bit 31 set and then with bit 31 clear returns the bank to counting.
- R9: Slot n's control A is at 0x50+0x10*n, control B is at 0x54+0x10*n and its count is at 0x58+0x10*n. Control A keeps only bits 31, 26 and 22:16, and the global register keeps only bits 31:29. All other bits, addresses and high halves of 32-bit slots read 0.
- R10: Control B stores any 32-bit value and has no effect on counting.
- R11: A write to a count address loads the written value. The two halves of slot 0 are written independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| shared_evt | input | 64 | Event pulses shared by all selectable slots |
| own_evt | input | NSEL*OWN_N (160) | Private event pulses, OWN_N per selectable slot |
| irq | output | 1 | Level-sensitive overflow interrupt |

## Verification
Several properties are checked on every cycle. A slot that is frozen, globally or locally, holds its count unless written. No count ever steps by more than one without a write. An enabled overflow always lands the controller in its tripped state on the next edge. A frozen controller leaves its state only on a global write. A falling interrupt always follows a write or a running cycle. Other behaviour can only be shown by the bench's scenarios. This includes the exact counts for each event code (shared, private, out of range), the carry between the halves of the cycle counter, the freeze of a neighbour slot at the moment another one trips, the gating of the interrupt by each of its three enables, the level staying high across an unfreeze, and the read-back masks of the control registers.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;
    localparam int SHARED_N    = 64;
    localparam int CODE_W      = 7;

    localparam logic [ADDR_W-1:0] GCTL_ADDR = 8'h40;
    localparam int                SLOT_TAG0 = 5;     // slot n sits at (5+n)<<4

    localparam logic [3:0] OFF_CTLA = 4'h0;
    localparam logic [3:0] OFF_CTLB = 4'h4;
    localparam logic [3:0] OFF_CLO  = 4'h8;
    localparam logic [3:0] OFF_CHI  = 4'hC;

    localparam int BIT_FRZ  = 31;
    localparam int BIT_IEN  = 30;
    localparam int BIT_FOC  = 29;
    localparam int BIT_CEN  = 26;
    localparam int CODE_LSB = 16;

    typedef enum logic [1:0] {
        ST_HALT    = 2'd0,
        ST_RUN     = 2'd1,
        ST_TRIPPED = 2'd2
    } mon_state_e;

endpackage

// File: rtl/evmon_ctl.sv
module evmon_ctl
    import evmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gwr,
    input  logic gw_frz,
    input  logic gw_ien,
    input  logic gw_foc,
    input  logic trip,
    output logic run,
    output logic frz_all,
    output logic ien,
    output logic foc
);

    mon_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            ien     <= 1'b0;
            foc     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (gwr) begin
                ien <= gw_ien;
                foc <= gw_foc;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (trip)
                    state_d = ST_TRIPPED;
                else if (gwr && gw_frz)
                    state_d = ST_HALT;
            end
            ST_HALT: begin
                if (gwr && !gw_frz)
                    state_d = ST_RUN;
            end
            ST_TRIPPED: begin
                if (gwr)
                    state_d = gw_frz ? ST_HALT : ST_RUN;
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_comb begin
        run     = (state_q == ST_RUN);
        frz_all = !run;
    end

    // R6
    trip_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (state_q == ST_TRIPPED));

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) && !gwr |=> (state_q == $past(state_q)));

endmodule

// File: rtl/evmon_slot.sv
module evmon_slot
    import evmon_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter bit IS_CYC = 1'b0,
    parameter int OWN_N  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SHARED_N-1:0] shared_evt,
    input  logic [OWN_N-1:0]  own_evt,
    output logic [DATA_W-1:0] ctl_a,
    output logic [DATA_W-1:0] ctl_b,
    output logic [CNT_W-1:0]  count,
    output logic              cen,
    output logic              trip_req
);

    localparam int OW_IW = (OWN_N > 1) ? $clog2(OWN_N) : 1;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic              fc_q, ce_q;
    logic [CODE_W-1:0] code_q;
    logic [DATA_W-1:0] b_q;
    logic [CNT_W-1:0]  cnt_q, inc_val, load_val;
    logic              sel_hit, hit, inc, any_wr;

    always_comb begin
        sel_hit = 1'b0;
        if (code_q[CODE_W-1] == 1'b0)
            sel_hit = shared_evt[code_q[CODE_W-2:0]];
        else if (int'(code_q[CODE_W-2:0]) < OWN_N)
            sel_hit = own_evt[code_q[OW_IW-1:0]];
    end

    assign hit     = IS_CYC ? 1'b1 : sel_hit;
    assign inc     = run && !fc_q && hit;
    assign inc_val = inc ? (cnt_q + ONE) : cnt_q;
    assign any_wr  = wr_lo || wr_hi;

    generate
        if (CNT_W > DATA_W) begin : g_wide
            assign load_val = {wr_hi ? wdata : inc_val[CNT_W-1:DATA_W],
                               wr_lo ? wdata : inc_val[DATA_W-1:0]};
        end else begin : g_narrow
            assign load_val = wr_lo ? wdata : inc_val;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fc_q   <= 1'b0;
            ce_q   <= 1'b0;
            code_q <= '0;
            b_q    <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_a) begin
                fc_q   <= wdata[BIT_FRZ];
                ce_q   <= wdata[BIT_CEN];
                code_q <= wdata[CODE_LSB +: CODE_W];
            end
            if (wr_b)
                b_q <= wdata;
            cnt_q <= load_val;
        end
    end

    assign ctl_a    = {fc_q, 4'b0, ce_q, 3'b0, code_q, 16'b0};
    assign ctl_b    = b_q;
    assign count    = cnt_q;
    assign cen      = ce_q;
    assign trip_req = inc && ce_q && !any_wr && !cnt_q[CNT_W-1] && inc_val[CNT_W-1];

    // R4 R5
    frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || fc_q) && !any_wr |=> $stable(cnt_q));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + ONE));

endmodule

// File: rtl/evmon_bank.sv
module evmon_bank
    import evmon_pkg::*;
#(
    parameter int NSEL  = 10,
    parameter int OWN_N = 16,
    parameter int CYC_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [SHARED_N-1:0]   shared_evt,
    input  logic [NSEL*OWN_N-1:0] own_evt,
    output logic                  irq
);

    localparam int NSLOT = NSEL + 1;

    logic [DATA_W-1:0] a_arr  [NSLOT];
    logic [DATA_W-1:0] b_arr  [NSLOT];
    logic [DATA_W-1:0] lo_arr [NSLOT];
    logic [DATA_W-1:0] hi_arr [NSLOT];
    logic [NSLOT-1:0]  hit_v, ce_v, msb_v, trip_v;

    logic [3:0] off;
    logic       gwr, run, frz_all, ien, foc, trip;

    assign off = reg_addr[3:0];
    assign gwr = reg_wr && (reg_addr == GCTL_ADDR);

    evmon_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .gwr     (gwr),
        .gw_frz  (reg_wdata[BIT_FRZ]),
        .gw_ien  (reg_wdata[BIT_IEN]),
        .gw_foc  (reg_wdata[BIT_FOC]),
        .trip    (trip),
        .run     (run),
        .frz_all (frz_all),
        .ien     (ien),
        .foc     (foc)
    );

    generate
        for (genvar i = 0; i < NSLOT; i++) begin : g_slot
            localparam logic [ADDR_W-5:0] TAG = (ADDR_W-4)'(SLOT_TAG0 + i);
            logic sw_a, sw_b, sw_lo, sw_hi;

            assign hit_v[i] = (reg_addr[ADDR_W-1:4] == TAG);
            assign sw_a     = reg_wr && hit_v[i] && (off == OFF_CTLA);
            assign sw_b     = reg_wr && hit_v[i] && (off == OFF_CTLB);
            assign sw_lo    = reg_wr && hit_v[i] && (off == OFF_CLO);

            if (i == 0) begin : g_cyc
                logic [CYC_W-1:0] cnt_w;
                assign sw_hi = reg_wr && hit_v[i] && (off == OFF_CHI);
                evmon_slot #(.CNT_W(CYC_W), .IS_CYC(1'b1), .OWN_N(OWN_N)) u_slot (
                    .clk (clk), .rst_n (rst_n), .run (run),
                    .wr_a (sw_a), .wr_b (sw_b), .wr_lo (sw_lo), .wr_hi (sw_hi),
                    .wdata (reg_wdata), .shared_evt (shared_evt), .own_evt ('0),
                    .ctl_a (a_arr[i]), .ctl_b (b_arr[i]), .count (cnt_w),
                    .cen (ce_v[i]), .trip_req (trip_v[i])
                );
                assign lo_arr[i] = cnt_w[DATA_W-1:0];
                assign hi_arr[i] = cnt_w[CYC_W-1:DATA_W];
                assign msb_v[i]  = cnt_w[CYC_W-1];
            end else begin : g_evt
                logic [DATA_W-1:0] cnt_n;
                assign sw_hi = 1'b0;
                evmon_slot #(.CNT_W(DATA_W), .IS_CYC(1'b0), .OWN_N(OWN_N)) u_slot (
                    .clk (clk), .rst_n (rst_n), .run (run),
                    .wr_a (sw_a), .wr_b (sw_b), .wr_lo (sw_lo), .wr_hi (sw_hi),
                    .wdata (reg_wdata), .shared_evt (shared_evt),
                    .own_evt (own_evt[(i-1)*OWN_N +: OWN_N]),
                    .ctl_a (a_arr[i]), .ctl_b (b_arr[i]), .count (cnt_n),
                    .cen (ce_v[i]), .trip_req (trip_v[i])
                );
                assign lo_arr[i] = cnt_n;
                assign hi_arr[i] = '0;
                assign msb_v[i]  = cnt_n[DATA_W-1];
            end
        end
    endgenerate

    assign trip = ien && foc && (|trip_v);
    assign irq  = ien && foc && (|(ce_v & msb_v));

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == GCTL_ADDR)
            reg_rdata = {frz_all, ien, foc, 29'b0};
        for (int i = 0; i < NSLOT; i++) begin
            if (hit_v[i]) begin
                unique case (off)
                    OFF_CTLA: reg_rdata = a_arr[i];
                    OFF_CTLB: reg_rdata = b_arr[i];
                    OFF_CLO:  reg_rdata = lo_arr[i];
                    OFF_CHI:  reg_rdata = hi_arr[i];
                    default:  reg_rdata = '0;
                endcase
            end
        end
    end

    // R7
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(reg_wr) || $past(run)));

endmodule

// File: tb/evmon_bank_tb.sv
`timescale 1ns/1ps
module evmon_bank_tb;

    localparam int NSEL  = 10;
    localparam int OWN_N = 16;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  reg_wr = 1'b0;
    logic [7:0]            reg_addr = '0;
    logic [31:0]           reg_wdata = '0;
    logic [31:0]           reg_rdata;
    logic [63:0]           shared_evt = '0;
    logic [NSEL*OWN_N-1:0] own_evt = '0;
    logic                  irq;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    evmon_bank #(.NSEL(NSEL), .OWN_N(OWN_N), .CYC_W(64)) u_dut (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .shared_evt (shared_evt), .own_evt (own_evt), .irq (irq)
    );

    localparam logic [7:0] GCTL = 8'h40;
    function automatic logic [7:0] a_of(int n);   return 8'(8'h50 + 16*n); endfunction
    function automatic logic [7:0] b_of(int n);   return 8'(8'h54 + 16*n); endfunction
    function automatic logic [7:0] c_of(int n);   return 8'(8'h58 + 16*n); endfunction

    localparam logic [63:0] SH_PAT  = 64'h8000_0000_0010_1000;  // bits 63,20,12
    localparam logic [15:0] OWN_PAT = 16'h0005;                 // private codes 64,66

    // {code, pulses, expected count} for slot 1
    localparam logic [47:0] VEC [6] = '{
        {8'd12, 8'd5, 32'd5},
        {8'd13, 8'd4, 32'd0},
        {8'd63, 8'd3, 32'd3},
        {8'd66, 8'd6, 32'd6},
        {8'd65, 8'd4, 32'd0},
        {8'd90, 8'd5, 32'd0}
    };

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        shared_evt = SH_PAT;
        own_evt    = '0;
        own_evt[15:0]  = OWN_PAT;
        own_evt[31:16] = 16'hFFFF;
        repeat (n) @(negedge clk);
        shared_evt = '0;
        own_evt    = '0;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v0, v1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rchk("R1 gctl", GCTL, 32'h8000_0000);
        rchk("R1 ctla1", a_of(1), 32'h0);
        rchk("R1 cnt1", c_of(1), 32'h0);
        rchk("R1 cyc lo", c_of(0), 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 event selection table
        for (int k = 0; k < 6; k++) begin
            wr(GCTL, 32'h8000_0000);
            wr(a_of(1), {9'b0, VEC[k][46:40], 16'b0});
            wr(c_of(1), 32'h0);
            wr(GCTL, 32'h0);
            pulse(int'(VEC[k][39:32]));
            wr(GCTL, 32'h8000_0000);
            rchk($sformatf("R2 code %0d", VEC[k][47:40]), c_of(1), VEC[k][31:0]);
        end

        // R4 global freeze overrides local
        wr(a_of(1), 32'h000C_0000);
        wr(c_of(1), 32'h0);
        pulse(5);
        rchk("R4 frozen bank", c_of(1), 32'h0);

        // R5 local freeze
        wr(a_of(1), 32'h800C_0000);
        wr(a_of(2), 32'h000C_0000);
        wr(c_of(2), 32'h0);
        wr(GCTL, 32'h0);
        pulse(4);
        wr(GCTL, 32'h8000_0000);
        rchk("R5 frozen slot", c_of(1), 32'h0);
        rchk("R5 free slot", c_of(2), 32'd4);

        // R3 R11 cycle counter carry and half writes
        wr(c_of(0) + 8'h4, 32'd5);
        wr(c_of(0), 32'hFFFF_FFFF);
        wr(GCTL, 32'h0);
        wr(GCTL, 32'h8000_0000);
        rchk("R3 lo after carry", c_of(0), 32'd1);
        rchk("R11 hi after carry", c_of(0) + 8'h4, 32'd6);
        wr(c_of(0), 32'h0);
        wr(c_of(0) + 8'h4, 32'h0);
        wr(GCTL, 32'h0);
        repeat (8) @(negedge clk);
        wr(GCTL, 32'h8000_0000);
        rchk("R3 cycles", c_of(0), 32'd10);

        // R6 overflow trip
        wr(a_of(1), 32'h040C_0000);
        wr(c_of(1), 32'h7FFF_FFFE);
        wr(a_of(2), 32'h000C_0000);
        wr(c_of(2), 32'h0);
        wr(GCTL, 32'h6000_0000);
        pulse(3);
        rchk("R6 tripped count", c_of(1), 32'h8000_0000);
        rchk("R6 neighbour frozen", c_of(2), 32'd2);
        rchk("R6 freeze set", GCTL, 32'hE000_0000);
        chk("R7 irq on trip", {31'b0, irq}, 32'h1);
        rd(c_of(0), v0);
        repeat (4) @(negedge clk);
        rd(c_of(0), v1);
        chk("R6 cycle frozen", v1, v0);

        // R8 R7 recovery sequence
        wr(GCTL, 32'hE000_0000);
        chk("R7 irq held frozen", {31'b0, irq}, 32'h1);
        wr(GCTL, 32'h6000_0000);
        rchk("R8 running", GCTL, 32'h6000_0000);
        chk("R7 level after unfreeze", {31'b0, irq}, 32'h1);
        wr(c_of(1), 32'h0);
        chk("R7 drop on msb clear", {31'b0, irq}, 32'h0);
        pulse(2);
        wr(GCTL, 32'h8000_0000);
        rchk("R8 resumed", c_of(2), 32'd4);

        // R7 gating by slot enable
        wr(a_of(1), 32'h000C_0000);
        wr(c_of(1), 32'h7FFF_FFFF);
        wr(GCTL, 32'h6000_0000);
        pulse(2);
        rchk("R6 no trip without ce", GCTL, 32'h6000_0000);
        rchk("R6 passes msb", c_of(1), 32'h8000_0001);
        chk("R7 no irq without ce", {31'b0, irq}, 32'h0);

        // R7 gating by global interrupt enable
        wr(GCTL, 32'h8000_0000);
        wr(a_of(1), 32'h040C_0000);
        wr(c_of(1), 32'h7FFF_FFFF);
        wr(GCTL, 32'h2000_0000);
        pulse(2);
        rchk("R6 no trip without ien", GCTL, 32'h2000_0000);
        chk("R7 no irq without ien", {31'b0, irq}, 32'h0);
        wr(GCTL, 32'hE000_0000);
        chk("R7 irq on enable", {31'b0, irq}, 32'h1);
        wr(c_of(1), 32'h0);
        chk("R7 irq cleared", {31'b0, irq}, 32'h0);

        // R9 R10 register map, masks and storage
        wr(a_of(3), 32'hFFFF_FFFF);
        rchk("R9 ctla mask", a_of(3), 32'h847F_0000);
        wr(b_of(3), 32'h1234_5678);
        rchk("R10 ctlb store", b_of(3), 32'h1234_5678);
        rchk("R9 unmapped", 8'h44, 32'h0);
        rchk("R9 narrow hi", c_of(1) + 8'h4, 32'h0);
        wr(GCTL, 32'h8000_0000);
        wr(a_of(3), 32'h000C_0000);
        wr(b_of(3), 32'hFFFF_FFFF);
        wr(c_of(3), 32'h0);
        wr(GCTL, 32'h0);
        pulse(3);
        wr(GCTL, 32'h8000_0000);
        rchk("R10 no effect", c_of(3), 32'd3);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule